// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a small fully associative translation buffer that system software fills and maintains directly. Software places a virtual page pair number, a page-size exponent and two 64-bit page descriptors on staging inputs, and a write command loads them into a chosen slot. The address-space identifier stored with the entry comes from the current-identifier input. Each slot maps two neighbouring pages through one tag. Address bit PS picks between them: the even page uses descriptor 0 and the odd page uses descriptor 1.

A lookup presents a virtual address and returns three results one cycle later: a hit or not-found flag, the lowest matching slot number, and the descriptor for the half that was addressed. A second command port clears entries. A 3-bit opcode selects which entries are cleared, using the global bit, the identifier and the address. Opcodes with no defined meaning are reported as illegal and change nothing. Page-table walking, privilege checks and the meaning of descriptor attribute bits are left to the surrounding logic. The block only stores those bits.

Top module: `pp_tlb`

## Requirements
- R1: After synchronous reset every slot is empty. `lk_hit`, `lk_miss` and `inv_illegal` are low, and any later lookup reports not-found until a write occurs.
- R2: A write loads slot `wr_idx` with `stg_vppn` (address bits 47:13), `stg_ps` and `cur_asid`, and marks the slot present. Both descriptors are copied as whole 64-bit words, bits 63:61 and 47:12 included, and a lookup that hits returns the word unchanged.
- R3: The stored global flag is the AND of bit 6 of the two staged descriptors.
- R4: A slot matches a lookup when it is present, its stored address agrees with the lookup address in every bit from PS+1 up to 47, and its identifier equals `cur_asid` or its global flag is set.
- R5: On a hit, `lk_lo` is descriptor 0 when lookup address bit PS of the matching slot is 0, and descriptor 1 when that bit is 1.
- R6: Results follow one cycle after `lk_en`. Exactly one of `lk_hit` and `lk_miss` is high in that cycle and neither is high otherwise. On a hit, `lk_idx` is the lowest matching slot.
- R7: On a not-found result, `lk_idx` and `lk_lo` keep their previous values.
- R8: Clear opcodes 0 and 1 empty every slot.
- R9: Clear opcode 2 empties only global slots. Opcode 3 empties only non-global slots.
- R10: Clear opcode 4 empties non-global slots whose identifier equals `inv_asid`.
- R11: Clear opcode 5 empties non-global slots whose identifier equals `inv_asid` and whose address matches `inv_va` under the R4 address rule.
- R12: Clear opcode 6 empties slots whose address matches `inv_va` and that are global or whose identifier equals `inv_asid`.
- R13: Clear opcode 7 raises `inv_illegal` for one cycle, in the cycle after `inv_en`, and leaves every slot as it was. A legal opcode never raises the flag.
- R14: A lookup issued in the same cycle as a write sees the contents from before the write. When a write and a clear coincide, the written slot stays present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load staged entry |
| wr_idx | input | 4 | Slot to load |
| stg_vppn | input | 35 | Staged virtual address bits 47:13 |
| stg_ps | input | 6 | Staged page-size exponent |
| cur_asid | input | 10 | Current address-space identifier (writes and lookups) |
| stg_lo0 | input | 64 | Staged even-page descriptor |
| stg_lo1 | input | 64 | Staged odd-page descriptor |
| lk_en | input | 1 | Start a lookup |
| lk_va | input | 48 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found an entry |
| lk_miss | output | 1 | Lookup found nothing |
| lk_idx | output | 4 | Lowest matching slot |
| lk_lo | output | 64 | Descriptor of the addressed half |
| inv_en | input | 1 | Issue a clear command |
| inv_op | input | 3 | Clear opcode |
| inv_asid | input | 10 | Identifier operand for clears |
| inv_va | input | 48 | Address operand for clears |
| inv_illegal | output | 1 | Illegal clear opcode seen |

## Verification
Lookup results and the illegal-opcode flag appear in the first cycle after the command. Writes and clears affect any lookup issued in the next cycle or later. The bench drives every command on a falling edge and drops it on the following falling edge. The rising edge between the two captures the command, so the bench samples the registered outputs at that second falling edge. Every lookup in the sweeps is therefore checked at that exact point. A lookup that shares its cycle with a write is checked against the contents from before the write, and a follow-up lookup confirms the new entry.

// File: rtl/pp_tlb_pkg.sv
package pp_tlb_pkg;

    localparam int VA_W      = 48;
    localparam int VPPN_LSB  = 13;
    localparam int VPPN_W    = VA_W - VPPN_LSB;
    localparam int ASID_W    = 10;
    localparam int PS_W      = 6;
    localparam int LO_W      = 64;
    localparam int GLB_BIT   = 6;
    localparam int OP_W      = 3;

    typedef struct packed {
        logic              present;
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [PS_W-1:0]   ps;
        logic [VPPN_W-1:0] vppn;
        logic [LO_W-1:0]   lo_even;
        logic [LO_W-1:0]   lo_odd;
    } tlb_ent_t;

    typedef enum logic [OP_W-1:0] {
        CLR_ALL_A    = 3'd0,
        CLR_ALL_B    = 3'd1,
        CLR_GLOBAL   = 3'd2,
        CLR_LOCAL    = 3'd3,
        CLR_ID       = 3'd4,
        CLR_ID_PAGE  = 3'd5,
        CLR_PAGE_ANY = 3'd6,
        CLR_BAD      = 3'd7
    } clr_op_e;

    // Tag compare: only bits at or above address bit PS+1 take part.
    function automatic logic pair_match(input logic [VPPN_W-1:0] a,
                                        input logic [VPPN_W-1:0] b,
                                        input logic [PS_W-1:0]   ps);
        logic [PS_W-1:0]   sh;
        logic [VPPN_W-1:0] keep;
        sh   = (ps > PS_W'(VPPN_LSB - 1)) ? ps - PS_W'(VPPN_LSB - 1) : '0;
        keep = {VPPN_W{1'b1}} << sh;
        return ((a ^ b) & keep) == '0;
    endfunction

    function automatic logic odd_half(input logic [VA_W-1:0] va,
                                      input logic [PS_W-1:0] ps);
        logic [VA_W-1:0] t;
        t = va >> ps;
        return t[0];
    endfunction

endpackage

// File: rtl/pp_tlb_cmp.sv
module pp_tlb_cmp
    import pp_tlb_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    output logic              addr_hit,
    output logic              asid_hit
);
    assign addr_hit = pair_match(ent.vppn, va[VA_W-1:VPPN_LSB], ent.ps);
    assign asid_hit = (ent.asid == asid);
endmodule

// File: rtl/pp_tlb_clr_dec.sv
module pp_tlb_clr_dec
    import pp_tlb_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            glb,
    input  logic            addr_hit,
    input  logic            asid_hit,
    output logic            kill
);
    always_comb begin
        unique case (clr_op_e'(op))
            CLR_ALL_A, CLR_ALL_B: kill = 1'b1;
            CLR_GLOBAL:           kill = glb;
            CLR_LOCAL:            kill = !glb;
            CLR_ID:               kill = !glb && asid_hit;
            CLR_ID_PAGE:          kill = !glb && asid_hit && addr_hit;
            CLR_PAGE_ANY:         kill = addr_hit && (glb || asid_hit);
            default:              kill = 1'b0;
        endcase
    end
endmodule

// File: rtl/pp_tlb_first.sv
module pp_tlb_first #(
    parameter  int N     = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign any = |req;
endmodule

// File: rtl/pp_tlb.sv
module pp_tlb
    import pp_tlb_pkg::*;
#(
    parameter  int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPPN_W-1:0] stg_vppn,
    input  logic [PS_W-1:0]   stg_ps,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [LO_W-1:0]   stg_lo0,
    input  logic [LO_W-1:0]   stg_lo1,
    input  logic              lk_en,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [LO_W-1:0]   lk_lo,
    input  logic              inv_en,
    input  logic [OP_W-1:0]   inv_op,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VA_W-1:0]   inv_va,
    output logic              inv_illegal
);

    tlb_ent_t           ents [N_ENT];
    tlb_ent_t           new_ent;
    logic [N_ENT-1:0]   lk_match;
    logic [N_ENT-1:0]   kill;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_first;
    logic               op_bad;
    logic [LO_W-1:0]    hit_lo;

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        logic lk_addr, lk_asid, iv_addr, iv_asid;

        pp_tlb_cmp u_lk_cmp (
            .ent(ents[g]), .va(lk_va), .asid(cur_asid),
            .addr_hit(lk_addr), .asid_hit(lk_asid)
        );
        pp_tlb_cmp u_iv_cmp (
            .ent(ents[g]), .va(inv_va), .asid(inv_asid),
            .addr_hit(iv_addr), .asid_hit(iv_asid)
        );
        pp_tlb_clr_dec u_dec (
            .op(inv_op), .glb(ents[g].glb),
            .addr_hit(iv_addr), .asid_hit(iv_asid), .kill(kill[g])
        );

        assign lk_match[g] = ents[g].present && lk_addr && (lk_asid || ents[g].glb);
    end

    pp_tlb_first #(.N(N_ENT)) u_first (
        .req(lk_match), .any(lk_any), .idx(lk_first)
    );

    assign hit_lo = odd_half(lk_va, ents[lk_first].ps) ? ents[lk_first].lo_odd
                                                        : ents[lk_first].lo_even;
    assign op_bad = (inv_op > OP_W'(CLR_PAGE_ANY));

    always_comb begin
        new_ent.present = 1'b1;
        new_ent.glb     = stg_lo0[GLB_BIT] & stg_lo1[GLB_BIT];
        new_ent.asid    = cur_asid;
        new_ent.ps      = stg_ps;
        new_ent.vppn    = stg_vppn;
        new_ent.lo_even = stg_lo0;
        new_ent.lo_odd  = stg_lo1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ents[i] <= '0;
            lk_hit      <= 1'b0;
            lk_miss     <= 1'b0;
            lk_idx      <= '0;
            lk_lo       <= '0;
            inv_illegal <= 1'b0;
        end else begin
            lk_hit      <= lk_en && lk_any;
            lk_miss     <= lk_en && !lk_any;
            inv_illegal <= inv_en && op_bad;
            if (lk_en && lk_any) begin
                lk_idx <= lk_first;
                lk_lo  <= hit_lo;
            end
            for (int i = 0; i < N_ENT; i++) begin
                if (inv_en && !op_bad && kill[i]) ents[i].present <= 1'b0;
            end
            if (wr_en) ents[wr_idx] <= new_ent;
        end
    end

endmodule

// File: rtl/pp_tlb_chk.sv
module pp_tlb_chk
    import pp_tlb_pkg::*;
#(
    parameter  int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_en,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic [IDX_W-1:0] lk_idx,
    input logic [LO_W-1:0]  lk_lo,
    input logic             inv_en,
    input logic [OP_W-1:0]  inv_op,
    input logic             inv_illegal
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!lk_hit && !lk_miss && !inv_illegal)); // R1

    AST_LK_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        lk_en |=> (lk_hit ^ lk_miss)); // R6

    AST_LK_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !lk_en |=> (!lk_hit && !lk_miss)); // R6

    AST_MISS_KEEPS_RESULT: assert property (@(posedge clk) disable iff (rst)
        lk_miss |-> ($stable(lk_idx) && $stable(lk_lo))); // R7

    AST_BAD_OP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (inv_en && inv_op == 3'd7) |=> inv_illegal); // R13

    AST_GOOD_OP_SILENT: assert property (@(posedge clk) disable iff (rst)
        !(inv_en && inv_op == 3'd7) |=> !inv_illegal); // R13
endmodule

bind pp_tlb pp_tlb_chk #(.N_ENT(N_ENT)) chk_i (.*);

// File: tb/pp_tlb_tb_top.sv
`timescale 1ns/1ps
module pp_tlb_tb_top;
    import pp_tlb_pkg::*;

    localparam int N  = 16;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              wr_en = 0;
    logic [IW-1:0]     wr_idx = '0;
    logic [VPPN_W-1:0] stg_vppn = '0;
    logic [PS_W-1:0]   stg_ps = '0;
    logic [ASID_W-1:0] cur_asid = '0;
    logic [LO_W-1:0]   stg_lo0 = '0, stg_lo1 = '0;
    logic              lk_en = 0;
    logic [VA_W-1:0]   lk_va = '0;
    logic              lk_hit, lk_miss, inv_illegal;
    logic [IW-1:0]     lk_idx;
    logic [LO_W-1:0]   lk_lo;
    logic              inv_en = 0;
    logic [OP_W-1:0]   inv_op = '0;
    logic [ASID_W-1:0] inv_asid = '0;
    logic [VA_W-1:0]   inv_va = '0;

    pp_tlb #(.N_ENT(N)) dut_i (.*);

    int n_chk = 0, n_err = 0;

    // independent model of slot contents
    logic            m_e [N];
    logic            m_g [N];
    logic [9:0]      m_asid [N];
    logic [5:0]      m_ps [N];
    logic [47:0]     m_va [N];
    logic [63:0]     m_lo0 [N], m_lo1 [N];
    logic [IW-1:0]   last_idx = '0;
    logic [63:0]     last_lo = '0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic addr_eq(input logic [47:0] a, input logic [47:0] b,
                                     input logic [5:0] ps);
        return ((a ^ b) >> (int'(ps) + 1)) == 48'd0;
    endfunction

    task automatic do_write(input int idx, input logic [47:0] va, input logic [5:0] ps,
                            input logic [9:0] asid, input logic [63:0] l0,
                            input logic [63:0] l1);
        @(negedge clk);
        wr_en = 1; wr_idx = IW'(idx); stg_vppn = va[47:13]; stg_ps = ps;
        cur_asid = asid; stg_lo0 = l0; stg_lo1 = l1;
        @(negedge clk);
        wr_en = 0;
        m_e[idx] = 1; m_g[idx] = l0[6] & l1[6]; m_asid[idx] = asid;
        m_ps[idx] = ps; m_va[idx] = va; m_lo0[idx] = l0; m_lo1[idx] = l1;
    endtask

    task automatic expect_lookup(input logic [47:0] va, input logic [9:0] asid,
                                 input string rq);
        int hit_i;
        hit_i = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_e[i] && addr_eq(va, m_va[i], m_ps[i]) && (asid == m_asid[i] || m_g[i]))
                hit_i = i;
        if (hit_i >= 0) begin
            last_idx = IW'(hit_i);
            last_lo  = ((va >> m_ps[hit_i]) & 48'd1) != 0 ? m_lo1[hit_i] : m_lo0[hit_i];
        end
        chk(rq, "hit", 64'(lk_hit), 64'(hit_i >= 0));
        chk(rq, "miss", 64'(lk_miss), 64'(hit_i < 0));
        chk(rq, "idx", 64'(lk_idx), 64'(last_idx));
        chk(rq, "lo", lk_lo, last_lo);
    endtask

    task automatic do_lookup(input logic [47:0] va, input logic [9:0] asid,
                             input string rq);
        @(negedge clk);
        lk_en = 1; lk_va = va; cur_asid = asid;
        @(negedge clk);
        lk_en = 0;
        expect_lookup(va, asid, rq);
    endtask

    task automatic do_inv(input logic [2:0] op, input logic [9:0] asid,
                          input logic [47:0] va, input string rq);
        logic k, ah, sh;
        @(negedge clk);
        inv_en = 1; inv_op = op; inv_asid = asid; inv_va = va;
        @(negedge clk);
        inv_en = 0;
        chk("R13", "illegal flag", 64'(inv_illegal), 64'(op == 3'd7));
        for (int i = 0; i < N; i++) begin
            ah = addr_eq(va, m_va[i], m_ps[i]);
            sh = (asid == m_asid[i]);
            case (op)
                3'd0, 3'd1: k = 1;
                3'd2: k = m_g[i];
                3'd3: k = !m_g[i];
                3'd4: k = !m_g[i] && sh;
                3'd5: k = !m_g[i] && sh && ah;
                3'd6: k = ah && (m_g[i] || sh);
                default: k = 0;
            endcase
            if (k) m_e[i] = 0;
        end
        if (rq.len() == 0) k = 0;
    endtask

    function automatic logic [47:0] base_va(input int i);
        return 48'(i + 1) << 30;
    endfunction

    function automatic logic [5:0] ps_of(input int i);
        return 6'(12 + (i % 4) * 3);
    endfunction

    // R2 R3: entries with mixed global bits, attribute bits high and low
    task automatic fill();
        logic [63:0] l0, l1;
        for (int i = 0; i < N; i++) begin
            l0 = 64'h8000_0000_0000_0001 | (64'(i) << 12) | 64'h3C;
            l1 = 64'h6000_0000_0000_0003 | (64'(i + 256) << 12);
            if (i % 4 == 0) begin l0[6] = 1; l1[6] = 1; end
            if (i % 4 == 1) begin l0[6] = 1; l1[6] = 0; end
            do_write(i, base_va(i) | ((i % 4 != 0) ? 48'h2000 : 48'h0), ps_of(i),
                     10'(i % 3), l0, l1);
        end
    endtask

    // R4 R5 R6 R7: every slot, both halves, four identifiers, plus near misses
    task automatic sweep(input string rq);
        for (int i = 0; i < N; i++) begin
            for (int a = 0; a < 4; a++) begin
                for (int h = 0; h < 2; h++)
                    do_lookup(base_va(i) | (48'(h) << ps_of(i)) | 48'h123, 10'(a), rq);
                do_lookup(base_va(i) ^ (48'd1 << (int'(ps_of(i)) + 1)), 10'(a), rq);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_e[i] = 0; m_g[i] = 0; m_asid[i] = '0; m_ps[i] = '0;
            m_va[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "hit after reset", 64'(lk_hit), 64'd0);
        chk("R1", "miss after reset", 64'(lk_miss), 64'd0);
        chk("R1", "illegal after reset", 64'(inv_illegal), 64'd0);
        do_lookup(base_va(0), 10'd0, "R1");

        fill();
        sweep("R4");

        // R6 lowest index wins: duplicate slot 3 into slot 15
        do_write(15, m_va[3], m_ps[3], m_asid[3], 64'h1111, 64'h2222);
        do_lookup(base_va(3), m_asid[3], "R6");
        chk("R6", "lowest idx", 64'(lk_idx), 64'd3);

        // R8..R13 each opcode, two operand sets
        for (int op = 0; op < 8; op++) begin
            fill();
            do_inv(3'(op), 10'd2, base_va(5) | (48'd1 << ps_of(5)), "R8");
            sweep(op < 2 ? "R8" : op < 4 ? "R9" : op == 4 ? "R10" :
                  op == 5 ? "R11" : op == 6 ? "R12" : "R13");
            fill();
            do_inv(3'(op), 10'd1, base_va(4), "R9");
            sweep(op < 2 ? "R8" : op < 4 ? "R9" : op == 4 ? "R10" :
                  op == 5 ? "R11" : op == 6 ? "R12" : "R13");
        end

        // R14 write and lookup in one cycle: lookup sees old contents
        fill();
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd7; stg_vppn = 35'h7_0000_0000 >> 0; stg_ps = 6'd12;
        cur_asid = 10'd9; stg_lo0 = 64'hABCD_0001; stg_lo1 = 64'hABCD_1001;
        lk_en = 1; lk_va = {stg_vppn, 13'h0};
        @(negedge clk);
        wr_en = 0; lk_en = 0;
        expect_lookup({stg_vppn, 13'h0}, 10'd9, "R14");
        m_e[7] = 1; m_g[7] = 0; m_asid[7] = 10'd9; m_ps[7] = 6'd12;
        m_va[7] = {stg_vppn, 13'h0}; m_lo0[7] = 64'hABCD_0001; m_lo1[7] = 64'hABCD_1001;
        do_lookup({stg_vppn, 13'h0}, 10'd9, "R14");
        chk("R14", "new slot", 64'(lk_idx), 64'd7);

        // R14 write with clear-all in one cycle: written slot survives
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd3; stg_vppn = base_va(3)[47:13]; stg_ps = 6'd13;
        cur_asid = 10'd4; stg_lo0 = 64'h55; stg_lo1 = 64'h77;
        inv_en = 1; inv_op = 3'd0;
        @(negedge clk);
        wr_en = 0; inv_en = 0;
        for (int i = 0; i < N; i++) m_e[i] = 0;
        m_e[3] = 1; m_g[3] = 0; m_asid[3] = 10'd4; m_ps[3] = 6'd13;
        m_va[3] = base_va(3); m_lo0[3] = 64'h55; m_lo1[3] = 64'h77;
        do_lookup(base_va(3), 10'd4, "R14");
        do_lookup(base_va(7), 10'd9, "R14");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule